// File: doc/BRIEF.md
# Segmented DAC Switch Decoder

This block turns an 8-bit sample into the switch controls of a segmented current-steering converter. The lower three bits of the sample drive three binary-weighted switches directly, worth 1, 2 and 4 units. The upper five bits are thermometer-decoded into 31 identical segments of 8 units each. Because of this split, a step across a multiple of eight turns on one segment and turns off the small binary switches. It does not toggle a large binary-weighted group of sources at once, so less charge moves at any single transition.

The sample is captured on the rising clock edge. The decoded switch word sits in a second register stage, so every switch changes on the same edge, two clocks after the sample is applied. Each primary control has an inverted twin that steers its current to the second output, so the two outputs always add up to 255 units. A sleep input parks both register stages and drives every control low. A monitor output gives the weighted sum of the active primary switches for verification.

Top module: `sdac_switch_decoder`

## Requirements
- R1: Segment control `seg_on_o[k]` (k = 0..30) is high exactly when the upper five bits of the decoded code (bits 7:3) are greater than k. The set of active segments is therefore always a contiguous run starting at bit 0.
- R2: `bin_on_o` equals bits 2:0 of the decoded code. Bit 0 carries weight 1, bit 1 weight 2 and bit 2 weight 4.
- R3: With sleep and reset low, the switch controls reflect the `code_i` value sampled two rising edges earlier. All controls change on the same edge.
- R4: When the code steps from a value whose bits 2:0 are 111 to the next value, all three binary controls turn off and exactly one more segment turns on.
- R5: While awake, `seg_off_o` and `bin_off_o` are the bitwise inverses of `seg_on_o` and `bin_on_o`. The primary weight plus the complementary weight is 255.
- R6: From the first rising edge that samples `sleep_i` high, every primary and complementary control is low, and `mon_o` reads 0.
- R7: While `sleep_i` is high, both register stages hold and `code_i` is ignored. On the first edge after release, the outputs show the code captured before sleep. On the next edge, they show the code applied after release.
- R8: A synchronous active-high reset clears both stages to code 0. Every primary control is low, and every complementary control is high (255 units).
- R9: `mon_o` equals 8 × (number of active segments) + the weighted value of `bin_on_o`. When awake, this equals the code applied two edges earlier.
- R10: Code 255 turns on all 31 segments and all three binary switches, with every complementary control low. Code 0 gives the reverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state updates on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| sleep_i | input | 1 | Low-power request, active high |
| code_i | input | 8 | Sample word, bit 7 most significant |
| seg_on_o | output | 31 | Primary segment enables (thermometer) |
| bin_on_o | output | 3 | Primary binary switch enables (weights 1, 2, 4) |
| seg_off_o | output | 31 | Complementary segment enables |
| bin_off_o | output | 3 | Complementary binary switch enables |
| mon_o | output | 8 | Weighted sum of the active primary switches |

## Verification
The bench goes after the carry transitions 7→8 and 127→128. A decoder that left a binary switch on there, or added two segments, would show a jump in weight instead of a single-unit step. It streams codes that change every cycle, so a design with one register stage, or with the binary and segment paths at different latencies, would show the wrong code or a mix of two codes. The bench also checks the extremes 0 and 255, where an off-by-one thermometer compare would lose or gain the top segment. Finally, it changes `code_i` during sleep. A design that kept loading during sleep would show the new code on the first edge after release instead of the held one.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    // default geometry: 8-bit word, 3 binary bits, rest thermometer
    localparam int CODE_W_DEF = 8;
    localparam int LSB_W_DEF  = 3;
endpackage

// File: rtl/sdac_therm_dec.sv
module sdac_therm_dec #(
    parameter int MSB_W = 5,
    localparam int SEG_N = (1 << MSB_W) - 1
) (
    input  logic [MSB_W-1:0] upper_i,
    output logic [SEG_N-1:0] therm_o
);
    // one comparator per segment: on when the upper field exceeds its index
    for (genvar k = 0; k < SEG_N; k++) begin : g_seg
        assign therm_o[k] = (int'(upper_i) > k);
    end
endmodule

// File: rtl/sdac_pipe.sv
module sdac_pipe
    import sdac_pkg::*;
#(
    parameter int CODE_W = CODE_W_DEF,
    parameter int LSB_W  = LSB_W_DEF,
    localparam int MSB_W = CODE_W - LSB_W,
    localparam int SEG_N = (1 << MSB_W) - 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              sleep_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [SEG_N-1:0]  seg_o,
    output logic [LSB_W-1:0]  bin_o,
    output logic              slp_o
);
    typedef struct packed {
        logic [CODE_W-1:0] code;   // stage 1: captured sample
        logic [SEG_N-1:0]  seg;    // stage 2: decoded segments
        logic [LSB_W-1:0]  bin;    // stage 2: binary switches
        logic              slp;    // registered sleep request
    } pipe_t;

    pipe_t st_d, st_q;
    logic [SEG_N-1:0] therm;

    sdac_therm_dec #(.MSB_W(MSB_W)) u_dec (
        .upper_i (st_q.code[CODE_W-1:LSB_W]),
        .therm_o (therm)
    );

    always_comb begin
        st_d     = st_q;
        st_d.slp = sleep_i;
        if (rst_i) begin
            st_d.code = '0;
            st_d.seg  = '0;
            st_d.bin  = '0;
        end else if (!sleep_i) begin
            st_d.code = code_i;
            st_d.seg  = therm;
            st_d.bin  = st_q.code[LSB_W-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign seg_o = st_q.seg;
    assign bin_o = st_q.bin;
    assign slp_o = st_q.slp;
endmodule

// File: rtl/sdac_weight.sv
module sdac_weight #(
    parameter int CODE_W = 8,
    parameter int LSB_W  = 3,
    localparam int MSB_W = CODE_W - LSB_W,
    localparam int SEG_N = (1 << MSB_W) - 1,
    localparam int SEG_WT = 1 << LSB_W
) (
    input  logic [SEG_N-1:0]  seg_i,
    input  logic [LSB_W-1:0]  bin_i,
    output logic [CODE_W-1:0] sum_o
);
    always_comb begin
        sum_o = CODE_W'(bin_i);
        for (int k = 0; k < SEG_N; k++) begin
            if (seg_i[k]) sum_o = sum_o + CODE_W'(SEG_WT);
        end
    end
endmodule

// File: rtl/sdac_switch_decoder.sv
module sdac_switch_decoder
    import sdac_pkg::*;
#(
    parameter int CODE_W = CODE_W_DEF,
    parameter int LSB_W  = LSB_W_DEF,
    localparam int MSB_W = CODE_W - LSB_W,
    localparam int SEG_N = (1 << MSB_W) - 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              sleep_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [SEG_N-1:0]  seg_on_o,
    output logic [LSB_W-1:0]  bin_on_o,
    output logic [SEG_N-1:0]  seg_off_o,
    output logic [LSB_W-1:0]  bin_off_o,
    output logic [CODE_W-1:0] mon_o
);
    logic [SEG_N-1:0] seg_q;
    logic [LSB_W-1:0] bin_q;
    logic             pipe_slp;

    sdac_pipe #(.CODE_W(CODE_W), .LSB_W(LSB_W)) u_pipe (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .sleep_i (sleep_i),
        .code_i  (code_i),
        .seg_o   (seg_q),
        .bin_o   (bin_q),
        .slp_o   (pipe_slp)
    );

    // steering: primary and inverted twins, all parked low while asleep
    always_comb begin
        if (pipe_slp) begin
            seg_on_o  = '0;
            bin_on_o  = '0;
            seg_off_o = '0;
            bin_off_o = '0;
        end else begin
            seg_on_o  = seg_q;
            bin_on_o  = bin_q;
            seg_off_o = ~seg_q;
            bin_off_o = ~bin_q;
        end
    end

    sdac_weight #(.CODE_W(CODE_W), .LSB_W(LSB_W)) u_wt (
        .seg_i (seg_on_o),
        .bin_i (bin_on_o),
        .sum_o (mon_o)
    );
endmodule

// File: rtl/sdac_switch_decoder_chk.sv
module sdac_switch_decoder_chk #(
    parameter int CODE_W = 8,
    parameter int LSB_W  = 3,
    localparam int MSB_W = CODE_W - LSB_W,
    localparam int SEG_N = (1 << MSB_W) - 1,
    localparam int FULL  = (1 << CODE_W) - 1
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              sleep_i,
    input logic [CODE_W-1:0] code_i,
    input logic [SEG_N-1:0]  seg_on_o,
    input logic [LSB_W-1:0]  bin_on_o,
    input logic [SEG_N-1:0]  seg_off_o,
    input logic [LSB_W-1:0]  bin_off_o,
    input logic [CODE_W-1:0] mon_o,
    input logic              pipe_slp
);
    logic [SEG_N-1:0] seg_inc;
    int               off_wt;

    assign seg_inc = seg_on_o + SEG_N'(1);

    always_comb begin
        off_wt = int'(bin_off_o) + 8 * $countones(seg_off_o);
    end

    // R1
    therm_contig_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (seg_inc & seg_on_o) == '0);

    // R5
    comp_sum_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !pipe_slp |-> (int'(mon_o) + off_wt == FULL));

    // R6
    sleep_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        pipe_slp |-> (seg_on_o == '0 && bin_on_o == '0 &&
                      seg_off_o == '0 && bin_off_o == '0));

    // R3
    latency_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(sleep_i, 1) && !$past(sleep_i, 2) &&
         !$past(rst_i, 1) && !$past(rst_i, 2)) |-> (mon_o == $past(code_i, 2)));

    // R8
    reset_state_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(rst_i) && !pipe_slp) |-> (seg_on_o == '0 && bin_on_o == '0 &&
                                         seg_off_o == '1 && bin_off_o == '1));
endmodule

bind sdac_switch_decoder sdac_switch_decoder_chk #(.CODE_W(CODE_W), .LSB_W(LSB_W)) u_chk (.*);

// File: tb/sim_sdac_switch_decoder.sv
`timescale 1ns/1ps
module sim_sdac_switch_decoder;
    localparam int N = 16;
    localparam logic [7:0] VEC [N] = '{
        8'd0, 8'd255, 8'd7, 8'd8, 8'd15, 8'd16, 8'd127, 8'd128,
        8'd1, 8'd254, 8'd85, 8'd170, 8'd63, 8'd64, 8'd200, 8'd31};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sleep = 1'b0;
    logic [7:0]  code = 8'd0;
    logic [30:0] seg_on, seg_off;
    logic [2:0]  bin_on, bin_off;
    logic [7:0]  mon;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    sdac_switch_decoder u0 (
        .clk_i(clk), .rst_i(rst), .sleep_i(sleep), .code_i(code),
        .seg_on_o(seg_on), .bin_on_o(bin_on), .seg_off_o(seg_off),
        .bin_off_o(bin_off), .mon_o(mon));

    function automatic logic [30:0] therm_of(input logic [7:0] c);
        logic [30:0] m = '0;
        for (int i = 0; i < 31; i++) if (i < int'(c[7:3])) m[i] = 1'b1;
        return m;
    endfunction

    function automatic int weight(input logic [30:0] s, input logic [2:0] b);
        int w = int'(b[0]) + 2 * int'(b[1]) + 4 * int'(b[2]);
        for (int i = 0; i < 31; i++) if (s[i]) w += 8;
        return w;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_code(input logic [7:0] c, input string tag);
        chk(seg_on == therm_of(c), {tag, " R1 seg_on"}, seg_on, therm_of(c));
        chk(bin_on == c[2:0], {tag, " R2 bin_on"}, bin_on, c[2:0]);
        chk(seg_off == ~therm_of(c) && bin_off == ~c[2:0], {tag, " R5 inverse"},
            {seg_off, bin_off}, {~therm_of(c), ~c[2:0]});
        chk(weight(seg_on, bin_on) + weight(seg_off, bin_off) == 255, {tag, " R5 sum"},
            weight(seg_on, bin_on) + weight(seg_off, bin_off), 255);
        chk(mon == c, {tag, " R9 R3 mon"}, mon, c);
    endtask

    task automatic check_quiet(input string tag);
        chk(seg_on == 0 && bin_on == 0 && seg_off == 0 && bin_off == 0 && mon == 0,
            {tag, " R6 quiet"}, {seg_on, bin_on, seg_off, bin_off, mon}, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        chk(seg_on == 0 && bin_on == 0, "R8 primary low", {seg_on, bin_on}, 0);
        chk(seg_off == '1 && bin_off == '1, "R8 complement high", {seg_off, bin_off}, 34'h3_ffff_ffff);
        chk(weight(seg_off, bin_off) == 255, "R8 complement weight", weight(seg_off, bin_off), 255);

        // streamed table: output at negedge i reflects VEC[i-2] (R3)
        for (int i = 0; i < N + 2; i++) begin
            if (i >= 2) check_code(VEC[i-2], $sformatf("table[%0d]", i - 2));
            if (i >= 2 && VEC[i-2] == 8'd255)
                chk(seg_on == '1 && bin_on == 3'd7 && seg_off == 0 && bin_off == 0,
                    "R10 full", {seg_on, bin_on}, 34'h3_ffff_ffff);
            if (i >= 2 && VEC[i-2] == 8'd0)
                chk(seg_on == 0 && bin_on == 0 && seg_off == '1, "R10 zero", seg_on, 0);
            if (i < N) code = VEC[i];
            @(negedge clk);
        end

        // R4: carry transitions
        for (int t = 0; t < 2; t++) begin
            logic [7:0] lo = (t == 0) ? 8'd7 : 8'd127;
            code = lo;
            repeat (3) @(negedge clk);
            code = lo + 8'd1;
            @(negedge clk);
            chk(mon == lo, "R3 one edge old", mon, lo);
            @(negedge clk);
            chk(bin_on == 0 && $countones(seg_on) == int'(lo[7:3]) + 1,
                "R4 carry", {seg_on, bin_on}, {therm_of(lo + 8'd1), 3'd0});
        end

        // R6 / R7: sleep
        code = 8'h5A;
        repeat (3) @(negedge clk);
        sleep = 1'b1;
        @(negedge clk);
        check_quiet("sleep entry");
        code = 8'hC3;
        repeat (3) @(negedge clk);
        check_quiet("sleep held");
        sleep = 1'b0;
        @(negedge clk);
        check_code(8'h5A, "R7 held code");
        @(negedge clk);
        check_code(8'hC3, "R7 resumed");

        // R8: reset mid-stream
        code = 8'd200;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_code(8'd0, "R8 mid reset");
        repeat (2) @(negedge clk);
        check_code(8'd200, "R8 after reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule